// File: doc/BRIEF.md
# Crypto engine control and status unit

This block is the host-facing register front end of an AES engine that is fed by an input DMA channel and an output DMA channel. The host selects the algorithm path, asks the key store to hand a stored key to the engine, and programs the message length, the initialization vector and both DMA channels. It then waits for a sticky completion or error status bit, or for the interrupt line, and finally reads back the IV that the engine saved.

The engine, key store and DMA report back through single-cycle strobes. The unit turns those strobes into sticky status bits, a self-clearing key-load busy flag and a saved-context-ready flag. The host clears the status bits with write-one-to-clear writes. The saved-context-ready flag clears on its own when the host reads the last IV word. The bus is a single-cycle register port. `addr_i` is a word index. Reads are combinational. Writes and read side effects take effect on the rising clock edge where `req_i` is high.

Top module: `crypto_ctrl_unit`

## Requirements
- R1: After reset, every register reads 0, and all of these outputs are 0: `dma_path_o`, `clk_en_o`, `key_req_o`, `start_o`, `irq_o`, `dma_en_o`, `msg_len_o` and `iv_o`.
- R2: Word 0 is the algorithm select register. Only bits 1:0 are stored, and only those bits read back. `dma_path_o` is 1 only while that field holds 2. `clk_en_o` is 1 while the field is nonzero, so writing 0 drops both outputs.
- R3: Word 4 is the key-area register. A write while the unit is idle latches `wdata_i[2:0]` onto `key_area_o`. In the following cycle `key_req_o` pulses high for one cycle. The register's bit 31 (busy) reads 1 from that write until the clock edge that samples `key_done_i` or `key_err_i`, and then reads 0. Bits 2:0 read back the area.
- R4: A write to word 4 while busy is ignored. No `key_req_o` pulse follows, and the area does not change.
- R5: Word 3 is the status register and is read-only. `done_i` sets bit 0, `key_err_i` sets bit 29 and `dma_err_i` sets bit 31. Each bit stays set until a write to word 2 with a 1 at the same position. A 0 in that position, or a 1 at any other position, leaves the bit unchanged. If a strobe and its clear arrive in the same cycle, the set wins. All other status bits read 0.
- R6: Word 1 is the interrupt enable register, with bits 0, 29 and 31 stored. `irq_o` is the OR of the status bits ANDed with the enable bits.
- R7: `start_o` pulses for one cycle after a write to word 7, or after a write to word 12 with bit 0 set. It pulses only if `dma_path_o` is 1 at the time of that write. A write to word 16 never starts the engine.
- R8: DMA channel c has three registers: control at word 12+4c (bit 0 is the enable, driving `dma_en_o[c]`), a 32-bit address at word 13+4c, and a 16-bit byte length at word 14+4c. The length register takes any value, including values that are not multiples of 16, and keeps the low 16 bits. All three read back their stored values and drive the channel's outputs.
- R9: Words 6 and 7 hold the low and high 32-bit halves of the message length. Both read back, and `msg_len_o` is {word 7, word 6}.
- R10: Words 8 to 11 are IV words 0 to 3, readable and writable, and IV word k drives `iv_o[32k+31:32k]`. An `iv_save_i` strobe loads all four words from `iv_data_i` and sets bit 30 of word 5. A host read of word 11 clears bit 30. Reads of words 8 to 10 leave it set.
- R11: Word 5 is the AES control register. Bits 29:0 are writable, read back and drive `aes_ctl_o`. Bit 30 is the read-only saved-context flag. Bit 31 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational) |
| dma_path_o | output | 1 | DMA path to the engine selected |
| clk_en_o | output | 1 | Control and DMA clock enable |
| key_req_o | output | 1 | One-cycle key transfer request |
| key_area_o | output | 3 | Key store area to transfer |
| key_done_i | input | 1 | Key reached the engine |
| key_err_i | input | 1 | Key transfer error strobe |
| aes_ctl_o | output | 30 | AES control bits |
| msg_len_o | output | 64 | Message length |
| start_o | output | 1 | One-cycle engine start |
| done_i | input | 1 | Operation complete strobe |
| dma_err_i | input | 1 | DMA or bus error strobe |
| iv_o | output | 128 | IV words 3..0 |
| iv_save_i | input | 1 | Engine stores final IV |
| iv_data_i | input | 128 | Final IV from the engine |
| dma_en_o | output | 2 | Channel enables |
| dma_addr_o | output | 64 | Channel base addresses, channel 0 low |
| dma_len_o | output | 32 | Channel byte lengths, channel 0 low |
| irq_o | output | 1 | Masked interrupt |

## Verification
The hardest cases to reach from the ports are the collisions: a status strobe landing in the same cycle as its clear write, and a second key request arriving while the first is still in flight. The stimulus forces both by driving the strobe and the bus write at the same falling edge. It also issues the second key-area write before pulsing `key_done_i`. The interrupt logic is swept over all 64 combinations of the three status bits and three enables. The saved-context flag is checked across reads of every IV word, so only the read of the last word clears it.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  localparam logic [5:0] IDX_ALG   = 6'd0;
  localparam logic [5:0] IDX_IEN   = 6'd1;
  localparam logic [5:0] IDX_ICLR  = 6'd2;
  localparam logic [5:0] IDX_ISTAT = 6'd3;
  localparam logic [5:0] IDX_KEY   = 6'd4;
  localparam logic [5:0] IDX_CTL   = 6'd5;
  localparam logic [5:0] IDX_LLO   = 6'd6;
  localparam logic [5:0] IDX_LHI   = 6'd7;
  localparam logic [5:0] IDX_IV0   = 6'd8;
  localparam logic [5:0] IDX_DMA0  = 6'd12;
  localparam int unsigned DMA_STRIDE = 4;

  localparam int unsigned ST_DONE   = 0;
  localparam int unsigned ST_KEYERR = 29;
  localparam int unsigned ST_BUSERR = 31;
  localparam logic [31:0] ST_MASK = (32'd1 << ST_DONE) | (32'd1 << ST_KEYERR) |
                                    (32'd1 << ST_BUSERR);
  localparam int unsigned CTX_BIT = 30;
endpackage

// File: rtl/ccu_irq.sv
module ccu_irq
  import ccu_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] set_i,
  input  logic        clr_we_i,
  input  logic        en_we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] status_o,
  output logic [31:0] enable_o,
  output logic        irq_o
);
  logic [31:0] clr_mask;
  assign clr_mask = clr_we_i ? wdata_i : 32'd0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      enable_o <= '0;
    end else begin
      status_o <= ((status_o & ~clr_mask) | set_i) & ST_MASK;  // set wins
      if (en_we_i) enable_o <= wdata_i & ST_MASK;
    end
  end

  assign irq_o = |(status_o & enable_o);

  a_r5_strobe_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_i & ST_MASK)) |=> ((status_o & $past(set_i & ST_MASK)) == $past(set_i & ST_MASK)));
  a_r5_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((status_o & $past(status_o)) == $past(status_o)));
endmodule

// File: rtl/ccu_keyload.sv
module ccu_keyload #(
  parameter int unsigned KA_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [KA_W-1:0] area_i,
  input  logic            done_i,
  input  logic            err_i,
  output logic            busy_o,
  output logic [KA_W-1:0] area_o,
  output logic            req_o
);
  logic accept;
  assign accept = wr_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      area_o <= '0;
      req_o  <= 1'b0;
    end else begin
      req_o <= accept;
      if (accept) begin
        busy_o <= 1'b1;
        area_o <= area_i;
      end else if (done_i || err_i) begin
        busy_o <= 1'b0;
      end
    end
  end

  a_r4_busy_ignores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_i) |=> ($stable(area_o) && !req_o));
  a_r3_busy_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (done_i || err_i)) |=> !busy_o);
endmodule

// File: rtl/ccu_ctx.sv
module ccu_ctx (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [3:0]   word_we_i,
  input  logic [31:0]  wdata_i,
  input  logic         save_i,
  input  logic [127:0] save_data_i,
  input  logic         rd_last_i,
  output logic [127:0] iv_o,
  output logic         rdy_o
);
  logic [3:0][31:0] iv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iv_q  <= '0;
      rdy_o <= 1'b0;
    end else if (save_i) begin
      iv_q  <= save_data_i;
      rdy_o <= 1'b1;
    end else begin
      for (int w = 0; w < 4; w++)
        if (word_we_i[w]) iv_q[w] <= wdata_i;
      if (rd_last_i) rdy_o <= 1'b0;
    end
  end

  assign iv_o = iv_q;

  a_r10_save_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_i |=> rdy_o);
  a_r10_last_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && rd_last_i && !save_i) |=> !rdy_o);
endmodule

// File: rtl/ccu_dma_ch.sv
module ccu_dma_ch #(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_we_i,
  input  logic          addr_we_i,
  input  logic          len_we_i,
  input  logic [31:0]   wdata_i,
  output logic          en_o,
  output logic [AW-1:0] addr_o,
  output logic [LW-1:0] len_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      addr_o <= '0;
      len_o  <= '0;
    end else begin
      if (ctl_we_i)  en_o   <= wdata_i[0];
      if (addr_we_i) addr_o <= wdata_i[AW-1:0];
      if (len_we_i)  len_o  <= wdata_i[LW-1:0];  // no block alignment
    end
  end
endmodule

// File: rtl/crypto_ctrl_unit.sv
module crypto_ctrl_unit
  import ccu_pkg::*;
#(
  parameter int unsigned KA_W   = 3,
  parameter int unsigned N_DMA  = 2,
  parameter int unsigned DMA_AW = 32,
  parameter int unsigned DMA_LW = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [5:0]              addr_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  output logic                    dma_path_o,
  output logic                    clk_en_o,
  output logic                    key_req_o,
  output logic [KA_W-1:0]         key_area_o,
  input  logic                    key_done_i,
  input  logic                    key_err_i,
  output logic [29:0]             aes_ctl_o,
  output logic [63:0]             msg_len_o,
  output logic                    start_o,
  input  logic                    done_i,
  input  logic                    dma_err_i,
  output logic [127:0]            iv_o,
  input  logic                    iv_save_i,
  input  logic [127:0]            iv_data_i,
  output logic [N_DMA-1:0]        dma_en_o,
  output logic [N_DMA*DMA_AW-1:0] dma_addr_o,
  output logic [N_DMA*DMA_LW-1:0] dma_len_o,
  output logic                    irq_o
);
  localparam int unsigned PADK = 31 - KA_W;

  logic wr, rd;
  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  logic [1:0]  alg_q;
  logic [31:0] len_lo_q, len_hi_q;
  logic        start_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alg_q     <= '0;
      aes_ctl_o <= '0;
      len_lo_q  <= '0;
      len_hi_q  <= '0;
      start_o   <= 1'b0;
    end else begin
      start_o <= start_d;
      if (wr && addr_i == IDX_ALG) alg_q     <= wdata_i[1:0];
      if (wr && addr_i == IDX_CTL) aes_ctl_o <= wdata_i[29:0];
      if (wr && addr_i == IDX_LLO) len_lo_q  <= wdata_i;
      if (wr && addr_i == IDX_LHI) len_hi_q  <= wdata_i;
    end
  end

  assign dma_path_o = (alg_q == 2'd2);
  assign clk_en_o   = |alg_q;
  assign msg_len_o  = {len_hi_q, len_lo_q};
  assign start_d    = dma_path_o && wr &&
                      ((addr_i == IDX_LHI) || (addr_i == IDX_DMA0 && wdata_i[0]));

  // status and interrupt
  logic [31:0] status, enable, set_vec;
  always_comb begin
    set_vec = '0;
    set_vec[ST_DONE]   = done_i;
    set_vec[ST_KEYERR] = key_err_i;
    set_vec[ST_BUSERR] = dma_err_i;
  end

  ccu_irq u_irq (
    .clk_i, .rst_ni,
    .set_i    (set_vec),
    .clr_we_i (wr && addr_i == IDX_ICLR),
    .en_we_i  (wr && addr_i == IDX_IEN),
    .wdata_i,
    .status_o (status),
    .enable_o (enable),
    .irq_o
  );

  // key load
  logic key_busy;
  ccu_keyload #(.KA_W(KA_W)) u_key (
    .clk_i, .rst_ni,
    .wr_i   (wr && addr_i == IDX_KEY),
    .area_i (wdata_i[KA_W-1:0]),
    .done_i (key_done_i),
    .err_i  (key_err_i),
    .busy_o (key_busy),
    .area_o (key_area_o),
    .req_o  (key_req_o)
  );

  // IV and saved context
  logic [3:0] iv_we;
  logic       ctx_rdy;
  always_comb
    for (int w = 0; w < 4; w++) iv_we[w] = wr && (addr_i == IDX_IV0 + 6'(w));

  ccu_ctx u_ctx (
    .clk_i, .rst_ni,
    .word_we_i   (iv_we),
    .wdata_i,
    .save_i      (iv_save_i),
    .save_data_i (iv_data_i),
    .rd_last_i   (rd && addr_i == IDX_IV0 + 6'd3),
    .iv_o,
    .rdy_o       (ctx_rdy)
  );

  // DMA channels
  logic [DMA_AW-1:0] ch_addr [N_DMA];
  logic [DMA_LW-1:0] ch_len  [N_DMA];

  for (genvar c = 0; c < N_DMA; c++) begin : g_ch
    localparam logic [5:0] BASE = 6'(IDX_DMA0 + DMA_STRIDE * c);
    ccu_dma_ch #(.AW(DMA_AW), .LW(DMA_LW)) u_ch (
      .clk_i, .rst_ni,
      .ctl_we_i  (wr && addr_i == BASE),
      .addr_we_i (wr && addr_i == BASE + 6'd1),
      .len_we_i  (wr && addr_i == BASE + 6'd2),
      .wdata_i,
      .en_o      (dma_en_o[c]),
      .addr_o    (ch_addr[c]),
      .len_o     (ch_len[c])
    );
    assign dma_addr_o[c*DMA_AW +: DMA_AW] = ch_addr[c];
    assign dma_len_o[c*DMA_LW +: DMA_LW]  = ch_len[c];
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      IDX_ALG:   rdata_o = {30'd0, alg_q};
      IDX_IEN:   rdata_o = enable;
      IDX_ISTAT: rdata_o = status;
      IDX_KEY:   rdata_o = {key_busy, {PADK{1'b0}}, key_area_o};
      IDX_CTL:   rdata_o = {1'b0, ctx_rdy, aes_ctl_o};
      IDX_LLO:   rdata_o = len_lo_q;
      IDX_LHI:   rdata_o = len_hi_q;
      default: begin
        for (int w = 0; w < 4; w++)
          if (addr_i == IDX_IV0 + 6'(w)) rdata_o = iv_o[32*w +: 32];
        for (int c = 0; c < N_DMA; c++) begin
          if (addr_i == 6'(IDX_DMA0 + DMA_STRIDE * c))     rdata_o = {31'd0, dma_en_o[c]};
          if (addr_i == 6'(IDX_DMA0 + DMA_STRIDE * c + 1)) rdata_o = 32'(ch_addr[c]);
          if (addr_i == 6'(IDX_DMA0 + DMA_STRIDE * c + 2)) rdata_o = 32'(ch_len[c]);
        end
      end
    endcase
  end

  a_r7_start_needs_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> dma_path_o);
  a_r7_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && !start_d) |=> !start_o);
endmodule

// File: tb/crypto_ctrl_unit_test.sv
module crypto_ctrl_unit_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic req = 0, we = 0;
  logic [5:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic dma_path, clk_en, key_req, key_done = 0, key_err = 0;
  logic [2:0] key_area;
  logic [29:0] aes_ctl;
  logic [63:0] msg_len;
  logic start, done = 0, dma_err = 0, iv_save = 0, irq;
  logic [127:0] iv, iv_data = 0;
  logic [1:0] dma_en;
  logic [63:0] dma_addr;
  logic [31:0] dma_len;

  crypto_ctrl_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .dma_path_o(dma_path), .clk_en_o(clk_en),
    .key_req_o(key_req), .key_area_o(key_area), .key_done_i(key_done),
    .key_err_i(key_err), .aes_ctl_o(aes_ctl), .msg_len_o(msg_len),
    .start_o(start), .done_i(done), .dma_err_i(dma_err), .iv_o(iv),
    .iv_save_i(iv_save), .iv_data_i(iv_data), .dma_en_o(dma_en),
    .dma_addr_o(dma_addr), .dma_len_o(dma_len), .irq_o(irq)
  );

  int total = 0, bad = 0;
  logic finished = 0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #2 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic strobe(input logic d, input logic k, input logic b);
    @(negedge clk); done = d; key_err = k; dma_err = b;
    @(negedge clk); done = 0; key_err = 0; dma_err = 0;
  endtask

  function automatic logic [31:0] stat_of(input logic [2:0] s);
    return {s[2], 1'b0, s[1], 28'd0, s[0]};
  endfunction

  logic [31:0] r;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 24; a++) begin
      bus_rd(6'(a), r);
      chk($sformatf("R1 reg %0d", a), r, 0);
    end
    chk("R1 outputs", {dma_path, clk_en, key_req, start, irq, dma_en}, 0);
    chk("R1 wide outputs", {msg_len, iv[63:0]}, 0);

    // R2 algorithm select sweep
    for (int v = 0; v < 4; v++) begin
      bus_wr(6'd0, 32'hFFFF_FFFC | 32'(v));
      bus_rd(6'd0, r);
      chk("R2 readback", r, 32'(v));
      chk("R2 path", dma_path, v == 2);
      chk("R2 clk_en", clk_en, v != 0);
    end

    // R7 start gating
    bus_wr(6'd0, 0);
    bus_wr(6'd7, 32'h1);
    chk("R7 no start without path (len hi)", start, 0);
    bus_wr(6'd12, 32'h1);
    chk("R7 no start without path (dma0)", start, 0);
    bus_wr(6'd0, 2);
    bus_wr(6'd7, 32'h0);
    chk("R7 start after len hi", start, 1);
    @(negedge clk);
    chk("R7 start one cycle", start, 0);
    bus_wr(6'd12, 32'h1);
    chk("R7 start after dma0 enable", start, 1);
    bus_wr(6'd12, 32'h0);
    chk("R7 no start on dma0 disable", start, 0);
    bus_wr(6'd16, 32'h1);
    chk("R7 no start on dma1", start, 0);

    // R9 message length
    bus_wr(6'd6, 32'hDEAD_0013);
    bus_wr(6'd7, 32'h0000_0002);
    bus_rd(6'd6, r); chk("R9 lo", r, 32'hDEAD_0013);
    bus_rd(6'd7, r); chk("R9 hi", r, 32'h2);
    chk("R9 msg_len_o", msg_len, 64'h2_DEAD_0013);

    // R8 DMA channels, unaligned lengths
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < 3; k++) begin
        logic [31:0] lv, av;
        lv = (k == 0) ? 32'd17 : (k == 1) ? 32'd33 : 32'h1_2345;
        av = 32'h1000_0000 * (c + 1) + 32'(k * 4);
        bus_wr(6'(13 + 4 * c), av);
        bus_wr(6'(14 + 4 * c), lv);
        bus_rd(6'(14 + 4 * c), r);
        chk($sformatf("R8 ch%0d len", c), r, lv & 32'hFFFF);
        bus_rd(6'(13 + 4 * c), r);
        chk($sformatf("R8 ch%0d addr", c), r, av);
        chk($sformatf("R8 ch%0d len out", c), dma_len[16*c +: 16], lv[15:0]);
        chk($sformatf("R8 ch%0d addr out", c), dma_addr[32*c +: 32], av);
      end
      bus_wr(6'(12 + 4 * c), 32'h3);
      bus_rd(6'(12 + 4 * c), r);
      chk($sformatf("R8 ch%0d en", c), {r, dma_en[c]}, {32'h1, 1'b1});
    end

    // R3 / R4 key load
    bus_wr(6'd4, 32'h5);
    chk("R3 key_req pulse", {key_req, key_area}, {1'b1, 3'd5});
    bus_rd(6'd4, r);
    chk("R3 busy", r, 32'h8000_0005);
    chk("R3 key_req single", key_req, 0);
    bus_wr(6'd4, 32'h2);
    chk("R4 no request while busy", key_req, 0);
    bus_rd(6'd4, r);
    chk("R4 area unchanged", {r, key_area}, {32'h8000_0005, 3'd5});
    @(negedge clk); key_done = 1;
    @(negedge clk); key_done = 0;
    bus_rd(6'd4, r);
    chk("R3 busy clears on done", r, 32'h5);
    bus_wr(6'd4, 32'h3);
    chk("R3 second request", {key_req, key_area}, {1'b1, 3'd3});
    strobe(0, 1, 0);
    bus_rd(6'd4, r);
    chk("R3 busy clears on error", r, 32'h3);
    bus_rd(6'd3, r);
    chk("R5 key error bit", r, 32'h2000_0000);
    bus_wr(6'd2, 32'hFFFF_FFFF);

    // R5 sticky bits
    for (int b = 0; b < 3; b++) begin
      logic [31:0] m;
      m = stat_of(3'(1 << b));
      strobe(b == 0, b == 1, b == 2);
      bus_rd(6'd3, r);
      chk($sformatf("R5 set bit%0d", b), r, m);
      bus_wr(6'd2, ~m);
      bus_rd(6'd3, r);
      chk($sformatf("R5 other clear no effect bit%0d", b), r, m);
      bus_wr(6'd2, m);
      bus_rd(6'd3, r);
      chk($sformatf("R5 cleared bit%0d", b), r, 0);
    end
    // set wins against simultaneous clear
    @(negedge clk); req = 1; we = 1; addr = 6'd2; wdata = 32'h1; done = 1;
    @(negedge clk); req = 0; we = 0; done = 0;
    bus_rd(6'd3, r);
    chk("R5 set wins", r, 32'h1);
    bus_wr(6'd2, 32'h1);

    // R6 interrupt sweep
    for (int s = 0; s < 8; s++)
      for (int e = 0; e < 8; e++) begin
        bus_wr(6'd2, 32'hFFFF_FFFF);
        bus_wr(6'd1, stat_of(3'(e)));
        if (s != 0) strobe(s[0], s[1], s[2]);
        chk($sformatf("R6 irq s=%0d e=%0d", s, e), irq, (s & e) != 0);
      end
    bus_rd(6'd1, r);
    chk("R6 enable readback", r, stat_of(3'd7));
    bus_wr(6'd2, 32'hFFFF_FFFF);
    bus_wr(6'd1, 0);

    // R11 AES control
    bus_wr(6'd5, 32'hFFFF_FFFF);
    bus_rd(6'd5, r);
    chk("R11 ctl readback", r, 32'h3FFF_FFFF);
    chk("R11 ctl out", aes_ctl, 30'h3FFF_FFFF);
    bus_wr(6'd5, 32'h0000_002C);

    // R10 IV
    for (int w = 0; w < 4; w++) bus_wr(6'(8 + w), 32'hA000_0000 + 32'(w));
    for (int w = 0; w < 4; w++) begin
      bus_rd(6'(8 + w), r);
      chk($sformatf("R10 iv%0d", w), r, 32'hA000_0000 + 32'(w));
    end
    chk("R10 iv out", iv, {32'hA000_0003, 32'hA000_0002, 32'hA000_0001, 32'hA000_0000});
    bus_rd(6'd5, r);
    chk("R10 flag clear before save", r[30], 0);
    @(negedge clk); iv_save = 1;
    iv_data = 128'h4444_4444_3333_3333_2222_2222_1111_1111;
    @(negedge clk); iv_save = 0;
    bus_rd(6'd5, r);
    chk("R10 flag set", r, 32'h4000_002C);
    for (int w = 0; w < 3; w++) begin
      bus_rd(6'(8 + w), r);
      chk($sformatf("R10 saved iv%0d", w), r, {4{4'(w + 1)}} * 32'h1111_1111 / 32'h1111);
      bus_rd(6'd5, r);
      chk($sformatf("R10 flag stays after iv%0d", w), r[30], 1);
    end
    bus_rd(6'd11, r);
    chk("R10 saved iv3", r, 32'h4444_4444);
    bus_rd(6'd5, r);
    chk("R10 flag cleared by last read", r[30], 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule